// File: doc/BRIEF.md
# I2C Master Command Front End

This block sits ahead of an I2C transaction engine. Software hands it one 32-bit control word per `cmd_valid` pulse. The word can do four things: start or stop the engine, load how many command bytes follow the slave address, load the length of a quarter SCL period in clocks, or flush the command queues. Once the engine runs, the block produces a quarter-period tick and drives SCL as an open-drain clock. Each SCL period is four ticks long: two low (low, then data setup) and two released high (high, then hold).

When the engine is stopped, software can drive each line by hand (bit-bang mode). A word whose delay-load flag is clear is a line-control word. Its two lowest 2-bit fields set SCL and SDA: no change, drive low, drive high, or release. Each line is modelled as an active-low output enable plus a driven level. The sampled pin values come back through a two-flop synchronizer. A queue flush holds the block busy for a fixed count of clocks and leaves the engine stopped until a new run command arrives.

Top module: `i2c_ctl_front`

## Requirements
- R1: After reset the engine is stopped, the block is not busy, the byte count is 0, no tick is produced, and both lines are released (`*_oe_n` = 1).
- R2: A run field (bits 13:12) of 3 starts the engine and 2 stops it, visible one cycle after the word. Values 0 and 1 leave the run state unchanged.
- R3: Bits 10:9 load into `byte_count` only when bit 11 is set. Otherwise the count keeps its value.
- R4: Bits 7:0 load into the quarter delay D only when bit 8 is set. While the engine runs with D > 0, `quarter_tick` pulses once every D clocks, the first time D cycles after the start word. There is no tick while stopped or when D = 0.
- R5: While running, SCL is driven low (`scl_oe_n` = 0) for quarter phases 0 and 1 and released for phases 2 and 3, each D clocks long. SDA stays released.
- R6: While stopped, a word with bit 8 clear applies code bits 1:0 to SCL and bits 3:2 to SDA, one cycle after the word. The codes are: 0 keeps the line's state, 1 drives it low, 2 drives it high (`oe_n` = 0, out = 1), and 3 releases it.
- R7: Line-control words that arrive while the engine runs are ignored. After a stop, the lines return to the bit-bang states they held before.
- R8: A word with bit 14 set raises `fifo_rst_busy` for exactly 16 cycles and stops the engine. The other fields of that word are ignored, and so is every word that arrives while busy.
- R9: `scl_sync` and `sda_sync` follow `scl_in` and `sda_in` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Control word strobe |
| cmd_word | input | 32 | Control word |
| scl_in | input | 1 | Sensed SCL pin level |
| sda_in | input | 1 | Sensed SDA pin level |
| running | output | 1 | Engine run state |
| fifo_rst_busy | output | 1 | Queue flush in progress |
| byte_count | output | 2 | Command bytes after the slave address |
| quarter_tick | output | 1 | One-clock pulse per quarter SCL period |
| scl_out | output | 1 | SCL driven level |
| scl_oe_n | output | 1 | SCL output enable, active low |
| sda_out | output | 1 | SDA driven level |
| sda_oe_n | output | 1 | SDA output enable, active low |
| scl_sync | output | 1 | Synchronized SCL input |
| sda_sync | output | 1 | Synchronized SDA input |

## Verification
Run state, byte count, delay, line overrides and the busy flag all show one cycle after the accepting edge. The first tick comes D cycles after the start word, and SCL stays low through cycles 1 to 2D and is released through 2D+1 to 4D. Synchronizer outputs lag the pin by two cycles, so a line override reaches them three cycles after its word. For every stimulus the bench queues each expected value with the absolute cycle it is due in, and the monitor compares it only in that cycle, half a clock after the edge.

// File: rtl/i2c_ctl_front.sv
module i2c_ctl_front #(
  parameter int CMD_W    = 32,
  parameter int DLY_W    = 8,
  parameter int DLY_INIT = 10,
  parameter int RST_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             running,
  output logic             fifo_rst_busy,
  output logic [1:0]       byte_count,
  output logic             quarter_tick,
  output logic             scl_out,
  output logic             scl_oe_n,
  output logic             sda_out,
  output logic             sda_oe_n,
  output logic             scl_sync,
  output logic             sda_sync
);
  localparam int RCW     = $clog2(RST_CLKS + 1);
  localparam int F_RST   = 14;
  localparam int F_RUN   = 12;
  localparam int F_LDB   = 11;
  localparam int F_BYTES = 9;
  localparam int F_LDD   = 8;

  logic [RCW-1:0]   rst_cnt;
  logic [DLY_W-1:0] qdly, qcnt;
  logic [1:0]       phase;
  logic [1:0]       bb_scl, bb_sda;
  logic [1:0]       scl_s, sda_s;
  logic             accept, do_rst, do_cmd, line_word;

  assign fifo_rst_busy = (rst_cnt != '0);
  assign accept        = cmd_valid && !fifo_rst_busy;
  assign do_rst        = accept && cmd_word[F_RST];
  assign do_cmd        = accept && !cmd_word[F_RST];
  assign line_word     = do_cmd && !cmd_word[F_LDD] && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt    <= '0;
      running    <= 1'b0;
      byte_count <= 2'd0;
      qdly       <= DLY_W'(DLY_INIT);
    end else begin
      if (fifo_rst_busy) rst_cnt <= rst_cnt - 1'b1;
      if (do_rst) begin
        rst_cnt <= RCW'(RST_CLKS);
        running <= 1'b0;
      end else if (do_cmd) begin
        if (cmd_word[F_RUN+1]) running    <= cmd_word[F_RUN];
        if (cmd_word[F_LDB])   byte_count <= cmd_word[F_BYTES +: 2];
        if (cmd_word[F_LDD])   qdly       <= cmd_word[DLY_W-1:0];
      end
    end
  end

  // line state encoded {oe_n, level}
  function automatic logic [1:0] line_next(input logic [1:0] cur, input logic [1:0] code);
    case (code)
      2'd1:    return 2'b00;
      2'd2:    return 2'b01;
      2'd3:    return 2'b11;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bb_scl <= 2'b11;
      bb_sda <= 2'b11;
    end else if (line_word) begin
      bb_scl <= line_next(bb_scl, cmd_word[1:0]);
      bb_sda <= line_next(bb_sda, cmd_word[3:2]);
    end
  end

  assign quarter_tick = running && (qdly != '0) && (qcnt >= qdly - DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt  <= '0;
      phase <= 2'd0;
    end else if (!running) begin
      qcnt  <= '0;
      phase <= 2'd0;
    end else if (quarter_tick) begin
      qcnt  <= '0;
      phase <= phase + 2'd1;
    end else if (qdly != '0) begin
      qcnt  <= qcnt + DLY_W'(1);
    end
  end

  assign scl_oe_n = running ? phase[1] : bb_scl[1];
  assign scl_out  = running ? 1'b0     : bb_scl[0];
  assign sda_oe_n = running ? 1'b1     : bb_sda[1];
  assign sda_out  = running ? 1'b1     : bb_sda[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
    end
  end

  assign scl_sync = scl_s[1];
  assign sda_sync = sda_s[1];
endmodule

module i2c_ctl_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [31:0] cmd_word,
  input logic        running,
  input logic        busy,
  input logic [1:0]  byte_count,
  input logic        quarter_tick,
  input logic        scl_oe_n,
  input logic        sda_oe_n
);
  assert_busy_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !running);

  assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_tick |-> running);

  assert_sda_free_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> sda_oe_n);

  assert_scl_changes_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(quarter_tick)) |-> $stable(scl_oe_n));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && !busy && !cmd_word[14] && cmd_word[13:12] == 2'b11) |-> running);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> $stable(byte_count));
endmodule

bind i2c_ctl_front i2c_ctl_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .running(running), .busy(fifo_rst_busy), .byte_count(byte_count),
  .quarter_tick(quarter_tick), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n)
);

// File: tb/sim_i2c_ctl_front.sv
`timescale 1ns/1ps
module sim_i2c_ctl_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic ext_sda_low = 1'b0;
  logic running, busy, tick, scl_out, scl_oe_n, sda_out, sda_oe_n, scl_sync, sda_sync;
  logic [1:0] byte_count;
  logic scl_pin, sda_pin;

  always #2.5 clk = ~clk;

  assign scl_pin = scl_oe_n ? 1'b1 : scl_out;
  assign sda_pin = sda_oe_n ? 1'b1 : sda_out;

  i2c_ctl_front u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .scl_in(scl_pin), .sda_in(sda_pin & ~ext_sda_low),
    .running(running), .fifo_rst_busy(busy), .byte_count(byte_count),
    .quarter_tick(tick), .scl_out(scl_out), .scl_oe_n(scl_oe_n),
    .sda_out(sda_out), .sda_oe_n(sda_oe_n), .scl_sync(scl_sync), .sda_sync(sda_sync)
  );

  localparam int B_BUSY = 10, B_RUN = 9, B_TICK = 8, B_BYTES = 6, B_SCL = 5,
                 B_SDA = 4, B_SCLOE = 3, B_SDAOE = 2, B_SCLS = 1, B_SDAS = 0;
  logic [10:0] obs;
  assign obs = {busy, running, tick, byte_count, scl_pin, sda_pin, scl_oe_n, sda_oe_n, scl_sync, sda_sync};

  int cyc = 0, base = 0, n_tests = 0, n_fail = 0;
  bit done = 0;
  int          q_cyc[$];
  logic [10:0] q_mask[$], q_val[$];
  string       q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] == cyc) begin
        n_tests++;
        if ((obs & q_mask[i]) !== (q_val[i] & q_mask[i])) begin
          n_fail++;
          $display("FAIL %s cycle %0d: actual %b expected %b mask %b",
                   q_req[i], cyc, obs & q_mask[i], q_val[i] & q_mask[i], q_mask[i]);
        end
        q_cyc.delete(i); q_mask.delete(i); q_val.delete(i); q_req.delete(i);
      end
    end
  end

  function automatic logic [31:0] mk(bit rst, logic [1:0] run, bit ldb, logic [1:0] nb, bit ldd, logic [7:0] d);
    return {17'd0, rst, run, ldb, nb, ldd, d};
  endfunction

  task automatic expect_bit(int n, int pos, logic v, string req);
    logic [10:0] m;
    m = 11'd1 << pos;
    q_cyc.push_back(base + n); q_mask.push_back(m);
    q_val.push_back(v ? m : 11'd0); q_req.push_back(req);
  endtask

  task automatic expect_bytes(int n, logic [1:0] v, string req);
    q_cyc.push_back(base + n); q_mask.push_back(11'b00011000000);
    q_val.push_back(11'(v) << B_BYTES); q_req.push_back(req);
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    base = cyc;
    cmd_valid = 1'b1;
    cmd_word = w;
  endtask

  task automatic release_cmd();
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); base = cyc;
    expect_bit(1, B_BUSY, 0, "R1"); expect_bit(1, B_RUN, 0, "R1");
    expect_bit(1, B_TICK, 0, "R1"); expect_bytes(1, 2'd0, "R1");
    expect_bit(1, B_SCLOE, 1, "R1"); expect_bit(1, B_SDAOE, 1, "R1");
    expect_bit(3, B_SCLS, 1, "R9"); expect_bit(3, B_SDAS, 1, "R9");
    idle(5);

    // R3 byte count load and hold
    issue(mk(0, 2'd0, 1, 2'd2, 1, 8'd10)); expect_bytes(1, 2'd2, "R3"); release_cmd(); idle(2);
    issue(mk(0, 2'd0, 0, 2'd3, 1, 8'd10)); expect_bytes(1, 2'd2, "R3"); release_cmd(); idle(2);

    // R6 bit-bang codes
    issue(mk(0, 2'd0, 0, 2'd0, 0, 8'h09));
    expect_bit(1, B_SCLOE, 0, "R6"); expect_bit(1, B_SCL, 0, "R6");
    expect_bit(1, B_SDAOE, 0, "R6"); expect_bit(1, B_SDA, 1, "R6");
    expect_bit(2, B_SCLS, 1, "R9"); expect_bit(3, B_SCLS, 0, "R9");
    release_cmd(); idle(4);
    issue(mk(0, 2'd0, 0, 2'd0, 0, 8'h04));
    expect_bit(1, B_SCL, 0, "R6"); expect_bit(1, B_SCLOE, 0, "R6");
    expect_bit(1, B_SDA, 0, "R6");
    release_cmd(); idle(4);
    issue(mk(0, 2'd0, 0, 2'd0, 0, 8'h0F));
    expect_bit(1, B_SCLOE, 1, "R6"); expect_bit(1, B_SDAOE, 1, "R6");
    expect_bit(1, B_SCL, 1, "R6"); expect_bit(1, B_SDA, 1, "R6");
    release_cmd(); idle(4);

    // R2 no-change run code while stopped
    issue(mk(0, 2'd1, 0, 2'd0, 1, 8'd10)); expect_bit(1, B_RUN, 0, "R2"); release_cmd(); idle(2);

    // R4/R5 run with D=4
    issue(mk(0, 2'd3, 0, 2'd0, 1, 8'd4));
    expect_bit(1, B_RUN, 1, "R2");
    for (int k = 1; k <= 8; k++) expect_bit(k, B_SCL, 0, "R5");
    for (int k = 9; k <= 16; k++) expect_bit(k, B_SCL, 1, "R5");
    expect_bit(17, B_SCL, 0, "R5");
    expect_bit(2, B_SDAOE, 1, "R5");
    expect_bit(3, B_TICK, 0, "R4"); expect_bit(4, B_TICK, 1, "R4");
    expect_bit(5, B_TICK, 0, "R4"); expect_bit(8, B_TICK, 1, "R4");
    release_cmd(); idle(6);

    // R7 line word while running is ignored
    issue(mk(0, 2'd1, 0, 2'd0, 0, 8'h05)); expect_bit(1, B_RUN, 1, "R2"); release_cmd(); idle(20);
    issue(mk(0, 2'd2, 0, 2'd0, 1, 8'd4));
    expect_bit(1, B_RUN, 0, "R2"); expect_bit(2, B_TICK, 0, "R4"); expect_bit(3, B_TICK, 0, "R4");
    expect_bit(1, B_SCLOE, 1, "R7"); expect_bit(1, B_SDAOE, 1, "R7");
    expect_bit(2, B_SCL, 1, "R7"); expect_bit(2, B_SDA, 1, "R7");
    release_cmd(); idle(4);

    // R4 D=1
    issue(mk(0, 2'd3, 0, 2'd0, 1, 8'd1));
    expect_bit(1, B_TICK, 1, "R4"); expect_bit(2, B_TICK, 1, "R4");
    expect_bit(2, B_SCL, 0, "R5"); expect_bit(3, B_SCL, 1, "R5"); expect_bit(5, B_SCL, 0, "R5");
    release_cmd(); idle(6);

    // R8 flush while running, then a start word during busy
    issue(mk(1, 2'd3, 1, 2'd1, 1, 8'd7));
    for (int k = 1; k <= 16; k++) expect_bit(k, B_BUSY, 1, "R8");
    expect_bit(17, B_BUSY, 0, "R8");
    expect_bit(1, B_RUN, 0, "R8"); expect_bytes(1, 2'd2, "R8");
    expect_bit(6, B_RUN, 0, "R8"); expect_bit(18, B_RUN, 0, "R8");
    release_cmd();
    cmd_valid = 1'b1; cmd_word = mk(0, 2'd3, 0, 2'd0, 1, 8'd2);
    @(negedge clk); cmd_valid = 1'b0; cmd_word = '0;
    idle(22);

    // R4 D=0 gives no tick
    issue(mk(0, 2'd3, 0, 2'd0, 1, 8'd0));
    expect_bit(1, B_RUN, 1, "R2");
    for (int k = 1; k <= 6; k++) expect_bit(k, B_TICK, 0, "R4");
    release_cmd(); idle(8);
    issue(mk(0, 2'd2, 0, 2'd0, 1, 8'd5)); expect_bit(1, B_RUN, 0, "R2"); release_cmd(); idle(3);

    // R9 external pull-down seen two cycles later
    @(negedge clk); base = cyc; ext_sda_low = 1'b1;
    expect_bit(1, B_SDAS, 1, "R9"); expect_bit(2, B_SDAS, 0, "R9");
    idle(4); ext_sda_low = 1'b0; idle(4);

    idle(30);
    if (q_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q_cyc.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule